// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits over several clock cycles and returns their full signed product of `2N` bits. A one-cycle `start` pulse captures both operands; the block then runs exactly `N` iterations. Each iteration looks at the lowest multiplier bit and the bit just to its right, and from that pair chooses whether to subtract the multiplicand from the upper product half, add it, or leave the upper half alone. The whole working register then shifts right by one place with sign extension.

The working register has `2N+1` bits: the upper product half, the multiplier (which becomes the lower product half as it shifts out), and one guard bit on the right that starts at zero. Because a string of ones in the multiplier costs one subtract where it begins and one add where it ends, and because every shift keeps the sign, signed operands need no pre- or post-correction. A one-cycle `done` pulse marks the result as valid. The result then holds until the next accepted start.

Top module: `booth_mul_r2`

## Requirements
- R1: When the examined pair (lowest multiplier bit, bit to its right) is 1,0, the iteration subtracts the multiplicand from the upper half.
- R2: When the examined pair is 0,1, the iteration adds the multiplicand to the upper half.
- R3: When the examined pair is 0,0 or 1,1, the iteration changes the upper half only through the shift.
- R4: An accepted start clears the upper half and the guard bit and loads the multiplier into the lower half.
- R5: After each iteration's arithmetic, the whole working register shifts right by one and its top bit is filled with the sign of the new upper half, so no add or subtract result is lost to overflow.
- R6: Exactly `N` iterations run; `done` is high for exactly one cycle, `N+1` rising edges after the edge that accepted `start`.
- R7: At `done`, `product` equals the signed product of the two captured operands, including the most negative value times itself and times the most positive value.
- R8: A `start` pulse that arrives while an operation is running is ignored: neither the running result nor its timing changes.
- R9: When idle, `product` keeps its last value until a new start is accepted.
- R10: During and straight after reset, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only when idle |
| mcand | input | N | Signed multiplicand, captured with start |
| mplier | input | N | Signed multiplier, captured with start |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Signed product, upper half first |

## Verification
The checker watches on every cycle that the recoder picks subtract, add or no arithmetic exactly as the examined bit pair demands, that a start is never taken while busy, that `done` lasts one cycle and follows the last iteration, and that the result stays still while idle. Whether the arithmetic shift and the guard bit of the adder give the right product, including the most negative operand cases and alternating or all-ones multipliers, only the bench's vectors can show, as can the exact `N+1` edge latency and the effect of a start dropped mid-operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    BOOTH_NONE = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

  // Pair is {current multiplier bit, bit to its right}.
  function automatic booth_op_e booth_pick(input logic cur_bit, input logic right_bit);
    booth_op_e op;
    case ({cur_bit, right_bit})
      2'b10:   op = BOOTH_SUB;
      2'b01:   op = BOOTH_ADD;
      default: op = BOOTH_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic       en,
  input  logic [1:0] pair,
  output logic       do_add,
  output logic       do_sub
);

  booth_op_e op;

  always_comb begin
    op     = booth_pick(pair[1], pair[0]);
    do_add = en && (op == BOOTH_ADD);
    do_sub = en && (op == BOOTH_SUB);
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int N = 8
) (
  input  logic [N:0]   upper,
  input  logic [N-1:0] operand,
  input  logic         do_add,
  input  logic         do_sub,
  output logic [N:0]   result
);

  localparam int EW = N + 1;

  logic [EW-1:0] opnd_ext;
  logic [EW-1:0] opnd_sel;
  logic [EW-1:0] carry_in;

  always_comb begin
    opnd_ext = {operand[N-1], operand};
    opnd_sel = do_sub ? ~opnd_ext : opnd_ext;
    carry_in = {{(EW-1){1'b0}}, do_sub};
    if (do_add || do_sub) result = upper + opnd_sel + carry_in;
    else                  result = upper;
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic busy,
  output logic last,
  output logic done
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  logic [CW-1:0] iter_cnt;

  assign load = start && !busy;
  assign last = busy && (iter_cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      iter_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy     <= 1'b1;
        iter_cnt <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      iter_cnt <= iter_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth_mul_r2.sv
module booth_mul_r2 #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           done,
  output logic [2*N-1:0] product
);

  localparam int RW = 2 * N + 1;

  logic [RW-1:0] work;
  logic [N-1:0]  mcand_q;
  logic          load;
  logic          busy;
  logic          last;
  logic          op_add;
  logic          op_sub;
  logic [1:0]    pair;
  logic [N:0]    upper_ext;
  logic [N:0]    upper_new;

  assign pair      = work[1:0];
  assign upper_ext = {work[RW-1], work[RW-1:N+1]};
  assign product   = work[RW-1:1];

  booth_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .busy  (busy),
    .last  (last),
    .done  (done)
  );

  booth_recode u_recode (
    .en     (busy),
    .pair   (pair),
    .do_add (op_add),
    .do_sub (op_sub)
  );

  booth_addsub #(.N(N)) u_addsub (
    .upper   (upper_ext),
    .operand (mcand_q),
    .do_add  (op_add),
    .do_sub  (op_sub),
    .result  (upper_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work    <= '0;
      mcand_q <= '0;
    end else if (load) begin
      work    <= {{N{1'b0}}, mplier, 1'b0};
      mcand_q <= mcand;
    end else if (busy) begin
      // N+1-bit sum on top keeps the true sign; dropping bit 0 is the shift.
      work <= {upper_new, work[N:1]};
    end
  end

endmodule

// File: rtl/booth_mul_r2_chk.sv
module booth_mul_r2_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load,
  input logic           busy,
  input logic           last,
  input logic           done,
  input logic           op_add,
  input logic           op_sub,
  input logic [1:0]     pair,
  input logic [2*N-1:0] product
);

  assert_sub_on_run_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pair == 2'b10) |-> (op_sub && !op_add));

  assert_add_on_run_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pair == 2'b01) |-> (op_add && !op_sub));

  assert_no_arith_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair[1] == pair[0] || !busy) |-> (!op_add && !op_sub));

  assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);

  assert_product_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(product));

endmodule

bind booth_mul_r2 booth_mul_r2_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .busy    (busy),
  .last    (last),
  .done    (done),
  .op_add  (op_add),
  .op_sub  (op_sub),
  .pair    (pair),
  .product (product)
);

// File: tb/test_booth_mul_r2.sv
module test_booth_mul_r2;

  localparam int N = 8;
  localparam int NV = 10;

  // {multiplicand, multiplier, expected product}
  localparam logic [4*N-1:0] VEC [NV] = '{
    {8'h02, 8'h07, 16'h000E},
    {8'h02, 8'hFD, 16'hFFFA},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC080},
    {8'h7F, 8'h7F, 16'h3F01},
    {8'h00, 8'hFF, 16'h0000},
    {8'hFF, 8'hFF, 16'h0001},
    {8'h55, 8'h55, 16'h1C39},
    {8'hF9, 8'hAA, 16'h025A},
    {8'h01, 8'h80, 16'hFF80}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           done;
  logic [2*N-1:0] product;

  int n_checks = 0;
  int n_fail = 0;
  int lat;

  always #2 clk = ~clk;

  booth_mul_r2 #(.N(N)) i_booth_mul_r2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .done    (done),
    .product (product)
  );

  task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Launch on a negedge, return latency in edges counted at negedges.
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, output int cycles);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 40) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    #7;
    check("R10 done in reset", {15'b0, done}, 16'h0);
    check("R10 product in reset", product, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10 done after reset", {15'b0, done}, 16'h0);

    // R1 R2 R3 R4 R5 R7: vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][4*N-1:3*N], VEC[i][3*N-1:2*N], lat);
      check($sformatf("R7 vector %0d product", i), product, VEC[i][2*N-1:0]);
      check($sformatf("R6 vector %0d latency", i), 16'(lat), 16'(N + 1));
    end

    // R6: done lasts one cycle
    run_op(8'h03, 8'h05, lat);
    check("R7 3x5", product, 16'h000F);
    @(negedge clk);
    check("R6 done drops", {15'b0, done}, 16'h0);

    // R9: product holds while idle, inputs wiggling
    mcand = 8'hAB; mplier = 8'hCD;
    repeat (6) @(negedge clk);
    check("R9 product held", product, 16'h000F);
    check("R9 no stray done", {15'b0, done}, 16'h0);

    // R8: start during operation is ignored
    @(negedge clk);
    start = 1'b1; mcand = 8'hFA; mplier = 8'h09;   // -6 x 9
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; mcand = 8'h7F; mplier = 8'h7F;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency unchanged", 16'(lat), 16'(N + 1));
    check("R8 result from first start", product, 16'hFFCA);
    repeat (12) begin
      @(negedge clk);
      if (done) check("R8 extra done", 16'h1, 16'h0);
    end
    check("R8 R9 product after ignored start", product, 16'hFFCA);

    // R4: back-to-back, prior result must not leak into new one
    run_op(8'h80, 8'h80, lat);
    run_op(8'h01, 8'h01, lat);
    check("R4 fresh upper half", product, 16'h0001);

    // R5: multiplier with sign flips every bit
    run_op(8'h81, 8'hAA, lat);
    check("R5 -127 x -86", product, 16'h2AAA);

    finish_run();
  end

endmodule